// File: doc/BRIEF.md
# Software-Strobed Supervision Timer with Status Lamp

This block guards an embedded processor card against a stalled program. Firmware programs a 16-bit reload value and then enables the timer. From then on a down-counter loses one count per prescaled tick, and firmware must keep reloading it with strobe writes. If the strobes stop, the counter halts at zero. The block then raises a sticky interrupt that reports a runaway processor or a runaway operation.

The same block drives one status lamp. The lamp is lit from reset until firmware reports a passed power-on self-test. It lights again on a timer expiry or on a hardware-error flag that firmware raises. Firmware reaches the block through a small register window: a reload register, a control/status port with a 4-bit status field, and a read-only view of the live count.

Register window (`bus_addr`):
- 0: reload value, read/write.
- 1: control on write, status on read.
- 2: current count, read-only.
- 3: reads as zero.

Control write bits:
- bit0: run level.
- bit1: strobe.
- bit2: self-test passed.
- bit3: error set.
- bit4: expiry acknowledge.
- bit5: error clear.

Top module: `cardwatch_top`

## Requirements
- R1: A synchronous active-low reset leaves the timer stopped, clears the expiry, error and self-test flags, sets the reload register to all ones and the count to zero. After reset the lamp is on and the interrupt is off.
- R2: A control write with bit0 = 1 while the timer is stopped loads the count from the reload register at that edge. After that the count falls by one every PRESCALE clocks.
- R3: A control write with bit1 = 1 while the timer runs reloads the count at that edge and restarts the tick phase. It wins over a tick that falls on the same edge.
- R4: A strobe (bit1) while the timer is stopped changes neither the count nor the status.
- R5: The count stops at zero and never wraps. One clock after a running timer shows a zero count, the expiry flag and `wd_irq` go high. This includes a reload value of 0.
- R6: The expiry flag and `wd_irq` stay high until a control write with bit4 = 1 clears them at that edge. Acknowledge wins over a same-edge re-trigger, but a running timer still at zero raises the flag again one clock later.
- R7: `status_led` = (self-test not passed) OR expiry flag OR error flag.
- R8: Control bit3 sets the error flag. Bit5 clears it, and bit3 wins when both are written together. Nothing else but reset changes the flag.
- R9: A read of address 1 returns run in bit0, expiry in bit1, error in bit2 and self-test-passed in bit3, with all higher bits zero. Address 0 returns the reload value and address 2 the count.
- R10: A control write with bit0 = 0 stops the timer, and the count then holds its value.
- R11: Once control bit2 has been written as 1, the self-test-passed flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register window |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from `bus_addr` |
| wd_irq | output | 1 | Sticky expiry interrupt |
| status_led | output | 1 | Status lamp, high = lit |

## Verification
A wrong count or a wrong tick phase shows up at address 2 within one prescale period. It also moves the expiry one clock after zero to a different cycle, so the bench reads the count just before and just after each tick, and samples the status on the exact cycle the expiry should appear. Flag latches that leak, wrap or lose stickiness show up in the status word or on `status_led` and `wd_irq` on the clock after the write that should or should not have moved them. Every bus write is therefore followed at once by a status read.

// File: rtl/cw_pkg.sv
// Package: shared register addresses and bit positions of the supervision timer.
// Assumes a two-bit register select; the positions are what firmware decodes.
package cw_pkg;
    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_COUNT  = 2'd2;

    // Control write bit positions
    localparam int C_RUN   = 0;
    localparam int C_KICK  = 1;
    localparam int C_POST  = 2;
    localparam int C_ESET  = 3;
    localparam int C_ACK   = 4;
    localparam int C_ECLR  = 5;

    localparam int STAT_W = 4;

    // Decoded one-cycle commands from a control write
    typedef struct packed {
        logic post_set;
        logic err_set;
        logic err_clr;
        logic tmo_ack;
    } cw_cmd_t;
endpackage

// File: rtl/cw_regs.sv
// Register window: holds the reload value and run bit, decodes control writes
// into one-cycle commands, and returns read data combinationally.
// Assumes the write strobe lasts one clock per access.
module cw_regs #(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [1:0]              addr,
    input  logic [CNT_W-1:0]        wdata,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [cw_pkg::STAT_W-1:0] flags_in,
    output logic [CNT_W-1:0]        reload_q,
    output logic                    run_q,
    output logic                    load,
    output cw_pkg::cw_cmd_t         cmd,
    output logic [CNT_W-1:0]        rdata
);
    import cw_pkg::*;

    logic wr_ctrl;
    logic wr_reload;

    assign wr_ctrl   = wr && (addr == A_CTRL);
    assign wr_reload = wr && (addr == A_RELOAD);

    // Reload register: all ones after reset, replaced by a write to address 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '1;
        else if (wr_reload)
            reload_q <= wdata;
    end

    // Run bit follows the level written in control bit0
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (wr_ctrl)
            run_q <= wdata[C_RUN];
    end

    // Count load: on a start from stopped, or on a strobe while running
    assign load = wr_ctrl && ((wdata[C_RUN] && !run_q) || (wdata[C_KICK] && run_q));

    // Flag commands, valid only during a control write
    always_comb begin
        cmd.post_set = wr_ctrl && wdata[C_POST];
        cmd.err_set  = wr_ctrl && wdata[C_ESET];
        cmd.err_clr  = wr_ctrl && wdata[C_ECLR];
        cmd.tmo_ack  = wr_ctrl && wdata[C_ACK];
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            A_RELOAD: rdata = reload_q;
            A_CTRL:   rdata = {{(CNT_W-STAT_W){1'b0}}, flags_in};
            A_COUNT:  rdata = cnt;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cw_prescale.sv
// Tick divider: produces a one-clock tick every PRESCALE clocks while running.
// The phase restarts on a count load and is held at zero while stopped.
module cw_prescale #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int P_W = $clog2(PRESCALE);
            localparam logic [P_W-1:0] P_LAST = P_W'(PRESCALE - 1);
            logic [P_W-1:0] phase_q;

            // Phase counter wraps at the last value
            always_ff @(posedge clk) begin
                if (!rst_n || !run || restart)
                    phase_q <= '0;
                else if (phase_q == P_LAST)
                    phase_q <= '0;
                else
                    phase_q <= phase_q + 1'b1;
            end

            assign tick = run && (phase_q == P_LAST);
        end
    endgenerate
endmodule

// File: rtl/cw_downcount.sv
// Timeout counter: loads from the reload value, decrements on each tick
// while running, and halts at zero instead of wrapping.
module cw_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             run,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             at_zero
);
    assign at_zero = (cnt_q == '0);

    // Load wins over a tick; no decrement below zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= reload;
        else if (run && tick && !at_zero)
            cnt_q <= cnt_q - CNT_W'(1);
    end
endmodule

// File: rtl/cw_flags.sv
// Flag latches and lamp: sticky expiry, firmware error and self-test flags,
// with the lamp lit unless self-test passed and no fault flag is set.
module cw_flags (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            at_zero,
    input  cw_pkg::cw_cmd_t cmd,
    output logic            tmo_q,
    output logic            err_q,
    output logic            post_q,
    output logic            led
);
    // Expiry: acknowledge clears, a running timer at zero sets
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmo_q <= 1'b0;
        else if (cmd.tmo_ack)
            tmo_q <= 1'b0;
        else if (run && at_zero)
            tmo_q <= 1'b1;
    end

    // Error flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (cmd.err_set)
            err_q <= 1'b1;
        else if (cmd.err_clr)
            err_q <= 1'b0;
    end

    // Self-test passed: set once, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            post_q <= 1'b0;
        else if (cmd.post_set)
            post_q <= 1'b1;
    end

    assign led = !post_q || tmo_q || err_q;
endmodule

// File: rtl/cardwatch_top.sv
// Top of the supervision timer: register window, tick divider, timeout
// counter and flag latches. Assumes a single clock and synchronous reset.
module cardwatch_top #(
    parameter int CNT_W    = 16,
    parameter int PRESCALE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             wd_irq,
    output logic             status_led
);
    import cw_pkg::*;

    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic              load;
    logic              tick;
    logic              at_zero;
    logic              tmo_q;
    logic              err_q;
    logic              post_q;
    logic [STAT_W-1:0] flags;
    cw_cmd_t           cmd;

    assign flags = {post_q, err_q, tmo_q, run_q};

    cw_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt_q), .flags_in(flags),
        .reload_q(reload_q), .run_q(run_q), .load(load), .cmd(cmd),
        .rdata(bus_rdata)
    );

    cw_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(load), .tick(tick)
    );

    cw_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .reload(reload_q),
        .run(run_q), .tick(tick), .cnt_q(cnt_q), .at_zero(at_zero)
    );

    cw_flags u_flags (
        .clk(clk), .rst_n(rst_n), .run(run_q), .at_zero(at_zero), .cmd(cmd),
        .tmo_q(tmo_q), .err_q(err_q), .post_q(post_q), .led(status_led)
    );

    assign wd_irq = tmo_q;
endmodule

// File: rtl/cardwatch_chk.sv
// Checker: temporal properties of the supervision timer, bound into the top.
module cardwatch_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             led,
    input logic             run,
    input logic             load,
    input logic [CNT_W-1:0] cnt,
    input logic             ack,
    input logic             post,
    input logic             err,
    input logic             err_clr
);
    // R7: an interrupt always shows on the lamp
    p_irq_lamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> led);

    // R7: lamp lit while self-test not passed
    p_post_lamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !post |-> led);

    // R5: a zero count without a load stays zero
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load) |=> (cnt == '0));

    // R6: interrupt persists until acknowledged
    p_sticky_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

    // R10 and R4: a stopped timer keeps its count unless started
    p_hold_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt));

    // R11: self-test flag never falls outside reset
    p_post_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> post);

    // R8: error flag holds without a clear command
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);
endmodule

bind cardwatch_top cardwatch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(wd_irq), .led(status_led), .run(run_q),
    .load(load), .cnt(cnt_q), .ack(cmd.tmo_ack), .post(post_q), .err(err_q),
    .err_clr(cmd.err_clr)
);

// File: tb/cardwatch_top_tb.sv
module cardwatch_top_tb;
    localparam int CNT_W = 16;
    localparam int PS    = 4;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_WT = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  addr;
        logic [15:0] data;   // write data or wait cycles
        logic [15:0] exp;    // expected read data
        logic [1:0]  pins;   // expected {wd_irq, status_led}
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t v(logic [1:0] op, logic [1:0] a, logic [15:0] d,
                               logic [15:0] e, logic [1:0] p, logic [3:0] r);
        return '{op: op, addr: a, data: d, exp: e, pins: p, req: r};
    endfunction

    localparam int NV = 59;
    // Requirements walked: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    localparam vec_t VECS [NV] = '{
        v(OP_RD,1,0,16'h0000,2'b01,1),      // R1 status
        v(OP_RD,0,0,16'hFFFF,2'b01,1),      // R1 reload
        v(OP_RD,2,0,16'h0000,2'b01,1),      // R1 count
        v(OP_WR,0,16'd5,0,0,9),
        v(OP_RD,0,0,16'd5,2'b01,9),         // R9 reload readback
        v(OP_WR,1,16'h0002,0,0,4),          // strobe while stopped
        v(OP_RD,2,0,16'd0,2'b01,4),         // R4
        v(OP_RD,1,0,16'h0000,2'b01,4),      // R4
        v(OP_WR,1,16'h0001,0,0,2),          // start
        v(OP_RD,2,0,16'd5,2'b01,2),         // R2 loaded
        v(OP_RD,1,0,16'h0001,2'b01,9),      // R9 run bit
        v(OP_WT,0,16'd4,0,0,2),
        v(OP_RD,2,0,16'd4,2'b01,2),         // R2 one tick
        v(OP_WT,0,16'd3,0,0,2),
        v(OP_RD,2,0,16'd4,2'b01,2),         // R2 before next tick
        v(OP_WR,1,16'h0003,0,0,3),          // strobe on tick edge
        v(OP_RD,2,0,16'd5,2'b01,3),         // R3 reload wins
        v(OP_WT,0,16'd4,0,0,3),
        v(OP_RD,2,0,16'd4,2'b01,3),         // R3 phase restarted
        v(OP_WR,1,16'h0000,0,0,10),
        v(OP_WT,0,16'd20,0,0,10),
        v(OP_RD,2,0,16'd4,2'b01,10),        // R10 hold
        v(OP_RD,1,0,16'h0000,2'b01,10),     // R10 stopped
        v(OP_WR,0,16'd2,0,0,5),
        v(OP_WR,1,16'h0001,0,0,5),
        v(OP_RD,2,0,16'd2,2'b01,2),
        v(OP_WT,0,16'd8,0,0,5),
        v(OP_RD,1,0,16'h0001,2'b01,5),      // R5 not yet
        v(OP_WT,0,16'd1,0,0,5),
        v(OP_RD,1,0,16'h0003,2'b11,5),      // R5 expiry
        v(OP_WT,0,16'd10,0,0,5),
        v(OP_RD,2,0,16'd0,2'b11,5),         // R5 no wrap
        v(OP_RD,1,0,16'h0003,2'b11,6),      // R6 sticky
        v(OP_WR,1,16'h0011,0,0,6),          // ack
        v(OP_RD,1,0,16'h0001,2'b01,6),      // R6 cleared
        v(OP_WT,0,16'd1,0,0,6),
        v(OP_RD,1,0,16'h0003,2'b11,6),      // R6 re-raised at zero
        v(OP_WR,1,16'h0013,0,0,6),          // ack + strobe
        v(OP_RD,1,0,16'h0001,2'b01,6),      // R6
        v(OP_RD,2,0,16'd2,2'b01,3),         // R3
        v(OP_WR,1,16'h0000,0,0,7),
        v(OP_WR,1,16'h0004,0,0,7),          // self-test passed
        v(OP_RD,1,0,16'h0008,2'b00,7),      // R7 lamp off
        v(OP_WR,1,16'h0008,0,0,8),
        v(OP_RD,1,0,16'h000C,2'b01,8),      // R8 set, lamp on
        v(OP_WR,1,16'h0000,0,0,8),
        v(OP_RD,1,0,16'h000C,2'b01,8),      // R8 holds
        v(OP_WR,1,16'h0028,0,0,8),
        v(OP_RD,1,0,16'h000C,2'b01,8),      // R8 set wins
        v(OP_WR,1,16'h0020,0,0,8),
        v(OP_RD,1,0,16'h0008,2'b00,8),      // R8 cleared
        v(OP_RD,1,0,16'h0008,2'b00,11),     // R11 still passed
        v(OP_WR,0,16'd0,0,0,5),
        v(OP_WR,1,16'h0001,0,0,5),
        v(OP_RD,1,0,16'h0009,2'b00,5),      // R5 zero reload
        v(OP_WT,0,16'd1,0,0,5),
        v(OP_RD,1,0,16'h000B,2'b11,7),      // R7 expiry lights lamp
        v(OP_WR,1,16'h0010,0,0,6),
        v(OP_RD,1,0,16'h0008,2'b00,6)       // R6 ack while stopping
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             wd_irq;
    logic             status_led;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cardwatch_top #(.CNT_W(CNT_W), .PRESCALE(PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_irq(wd_irq),
        .status_led(status_led)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, string tag, logic [15:0] exp, logic [1:0] pins);
        bus_addr = a;
        #1;
        check({tag, " data"}, 32'(bus_rdata), 32'(exp));
        check({tag, " pins"}, {30'd0, wd_irq, status_led}, {30'd0, pins});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Table walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                OP_WR: bus_write(VECS[i].addr, VECS[i].data);
                OP_RD: bus_read(VECS[i].addr, $sformatf("R%0d vec%0d", VECS[i].req, i),
                                VECS[i].exp, VECS[i].pins);
                default: repeat (int'(VECS[i].data)) @(negedge clk);
            endcase
        end
        // Directed R1: reset in the middle of operation
        bus_write(0, 16'd7);
        bus_write(1, 16'h0009);
        bus_read(1, "R8 pre-reset", 16'h000D, 2'b01);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 lamp in reset", {31'd0, status_led}, 32'd1);
        check("R1 irq in reset", {31'd0, wd_irq}, 32'd0);
        rst_n = 1'b1;
        bus_read(1, "R1 status after reset", 16'h0000, 2'b01);
        bus_read(0, "R1 reload after reset", 16'hFFFF, 2'b01);
        bus_read(2, "R1 count after reset", 16'h0000, 2'b01);
        // Directed R2: a full countdown from reload 1 expires after PS+1 clocks
        bus_write(0, 16'd1);
        bus_write(1, 16'h0001);
        repeat (PS) @(negedge clk);
        bus_read(1, "R2 zero reached", 16'h0001, 2'b01);
        @(negedge clk);
        bus_read(1, "R5 expiry after short count", 16'h0003, 2'b11);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule